// File: doc/BRIEF.md
# DRAM Data-Output Buffer Controller

This block decides, clock by clock, whether the four data pins of an asynchronous x4 DRAM drive data or float. It samples the active-low row strobe, column strobe, write enable and output enable on the system clock. It finds strobe edges by comparing each sampled value with the one from the previous clock. From the order of those edges it classifies each column access as a read, an early write, a read-modify-write, a late write, a refresh or an indeterminate access. Read data arrives from an array port. It is captured once per column access and held until the column strobe precharges.

The controller is a single state machine. `ST_PRECHG` is the column-precharged state, with outputs open and the data holder empty. From `ST_PRECHG`, a column-strobe fall with the row strobe high goes to `ST_REFRESH`. A fall that coincides with a write-enable fall goes to `ST_INDET`. A fall with write enable already low goes to `ST_EWRITE`. Any other fall goes to `ST_READ`, and the read data is captured on that transition. From `ST_READ`, a write-enable fall goes to `ST_LWRITE` when output enable is high, otherwise to `ST_RMW`. A row-strobe fall while in `ST_READ` is the hold-through-row transition, and `ST_READ` stays put. An output-enable fall in `ST_LWRITE` keeps `ST_LWRITE`. From every state other than `ST_PRECHG`, a high column strobe returns to `ST_PRECHG`.

All strobe inputs pass through one register stage before any decision is made. A strobe change therefore reaches the gating of the outputs one clock later. It reaches the state and the held data two clocks later.

Top module: `dqc_output_ctrl`

## Requirements
- R1: Whenever the column strobe sampled at the previous clock edge is high, `dq_oe` is 0. This also holds directly after reset.
- R2: A read starts when the column strobe falls while the row strobe is low and write enable is high. `rd_data` is captured at the second rising clock edge after `cas_n` goes low. From that edge, while output enable is low, `dq_oe` is 1 and `dq_out` shows the captured value.
- R3: Changes on `rd_data` after capture do not alter `dq_out` while the data is driven.
- R4: A high output enable opens the outputs. Returning it low while the column strobe stays low drives the same held data again.
- R5: Raising the row strobe and lowering it again while the column strobe stays low leaves `dq_out` and `dq_oe` unchanged. This includes a new row-strobe fall with new `rd_data`.
- R6: A column-strobe high pulse clears the held data and opens the outputs regardless of output enable. The next read drives freshly captured data.
- R7: If write enable is low for at least two clocks before the column strobe falls (early write), `dq_oe` stays 0 for the whole column access, whatever output enable does.
- R8: A write-enable fall during a read with output enable low (read-modify-write) keeps the read data driven and leaves `dq_indet` at 0.
- R9: A write-enable fall during a read with output enable high (late write) opens the outputs. They stay open when output enable later returns low, until the column strobe rises.
- R10: If write enable falls in the same sample as the column strobe, `dq_indet` is 1 and `dq_oe` is 0 until the column strobe rises.
- R11: A column-strobe fall with the row strobe high (refresh) keeps `dq_oe` at 0 until the column strobe rises, even if the row strobe then falls.
- R12: `dq_out` is all zeros whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DQ_W (4) | Read data from the array port |
| dq_out | output | DQ_W (4) | Data presented on the pins |
| dq_oe | output | 1 | 1 = pins driven, 0 = high impedance |
| dq_indet | output | 1 | Access classified as indeterminate |

## Verification
The bound checker watches the pin-level invariants on every cycle. It confirms that a high column strobe or a high output enable opens the outputs, and that driven data never changes between consecutive driven cycles. It also confirms that write states and the indeterminate flag never coincide with driving, and that open outputs carry zeros. The edge-order cases need directed scenarios, because only the sequence of strobe edges separates them. These cases are the capture latency, data held across a row-strobe cycle and across output-enable toggles, early versus late versus read-modify-write classification, simultaneous edges, refresh and fresh data after precharge.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

    // strobe vector positions (all strobes active low)
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_OE  = 3;
    localparam int NSTB    = 4;

    typedef enum logic [2:0] {
        ST_PRECHG  = 3'd0,
        ST_READ    = 3'd1,
        ST_RMW     = 3'd2,
        ST_EWRITE  = 3'd3,
        ST_LWRITE  = 3'd4,
        ST_INDET   = 3'd5,
        ST_REFRESH = 3'd6
    } cyc_state_t;

endpackage

// File: rtl/dqc_strobe_sync.sv
module dqc_strobe_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] cur,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_stb
        logic now_q;
        logic old_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                now_q <= 1'b1;
                old_q <= 1'b1;
            end else begin
                now_q <= strb_n[i];
                old_q <= now_q;
            end
        end

        assign cur[i]  = now_q;
        // active-low strobe asserted this sample, idle the one before
        assign fall[i] = old_q & ~now_q;
    end

endmodule

// File: rtl/dqc_rd_latch.sv
module dqc_rd_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         clear,
    input  logic [W-1:0] rd_data,
    output logic [W-1:0] q,
    output logic         vld
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q   <= '0;
            vld <= 1'b0;
        end else if (capture) begin
            q   <= rd_data;
            vld <= 1'b1;
        end
    end

endmodule

// File: rtl/dqc_cycle_fsm.sv
module dqc_cycle_fsm
    import dqc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTB-1:0] stb_cur,
    input  logic [NSTB-1:0] stb_fall,
    input  logic [W-1:0]    lat_q,
    input  logic            lat_vld,
    output logic            cap,
    output logic            clr,
    output cyc_state_t      state_o,
    output logic [W-1:0]    dq_out,
    output logic            dq_oe,
    output logic            dq_indet
);

    cyc_state_t state_q;
    cyc_state_t state_d;

    logic cas_hi;
    logic drive;

    assign cas_hi = stb_cur[STB_CAS];

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRECHG: begin
                if (stb_fall[STB_CAS]) begin
                    if (stb_cur[STB_RAS])
                        state_d = ST_REFRESH;
                    else if (stb_fall[STB_WE])
                        state_d = ST_INDET;
                    else if (!stb_cur[STB_WE])
                        state_d = ST_EWRITE;
                    else
                        state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (cas_hi)
                    state_d = ST_PRECHG;
                else if (stb_fall[STB_RAS])
                    state_d = ST_READ;      // hold-through-row
                else if (stb_fall[STB_WE])
                    state_d = stb_cur[STB_OE] ? ST_LWRITE : ST_RMW;
            end
            ST_LWRITE: begin
                if (cas_hi)
                    state_d = ST_PRECHG;
                else if (stb_fall[STB_OE])
                    state_d = ST_LWRITE;    // OE return keeps pins open
            end
            ST_RMW, ST_EWRITE, ST_INDET, ST_REFRESH: begin
                if (cas_hi)
                    state_d = ST_PRECHG;
            end
            default: state_d = ST_PRECHG;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_PRECHG;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        cap = (state_q == ST_PRECHG) && stb_fall[STB_CAS] &&
              !stb_cur[STB_RAS] && stb_cur[STB_WE];
        clr = cas_hi;
        drive = ((state_q == ST_READ) || (state_q == ST_RMW)) &&
                lat_vld && !cas_hi && !stb_cur[STB_OE];
        dq_oe    = drive;
        dq_out   = drive ? lat_q : '0;
        dq_indet = (state_q == ST_INDET);
        state_o  = state_q;
    end

endmodule

// File: rtl/dqc_output_ctrl.sv
module dqc_output_ctrl
    import dqc_pkg::*;
#(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [DQ_W-1:0] rd_data,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    output logic            dq_indet
);

    logic [NSTB-1:0] stb_raw;
    logic [NSTB-1:0] stb_cur;
    logic [NSTB-1:0] stb_fall;
    logic            cap;
    logic            clr;
    logic [DQ_W-1:0] lat_q;
    logic            lat_vld;
    cyc_state_t      cyc_state;

    always_comb begin
        stb_raw          = '1;
        stb_raw[STB_RAS] = ras_n;
        stb_raw[STB_CAS] = cas_n;
        stb_raw[STB_WE]  = we_n;
        stb_raw[STB_OE]  = oe_n;
    end

    dqc_strobe_sync #(.N(NSTB)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .strb_n (stb_raw),
        .cur    (stb_cur),
        .fall   (stb_fall)
    );

    dqc_rd_latch #(.W(DQ_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (cap),
        .clear   (clr),
        .rd_data (rd_data),
        .q       (lat_q),
        .vld     (lat_vld)
    );

    dqc_cycle_fsm #(.W(DQ_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stb_cur  (stb_cur),
        .stb_fall (stb_fall),
        .lat_q    (lat_q),
        .lat_vld  (lat_vld),
        .cap      (cap),
        .clr      (clr),
        .state_o  (cyc_state),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .dq_indet (dq_indet)
    );

endmodule

// File: rtl/dqc_output_ctrl_chk.sv
module dqc_output_ctrl_chk
    import dqc_pkg::*;
#(
    parameter int DQ_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cas_n,
    input logic            oe_n,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe,
    input logic            dq_indet,
    input cyc_state_t      st
);

    assert_cas_high_open_R1: assert property (@(posedge clk) disable iff (rst)
        $past(cas_n) |-> !dq_oe);

    assert_driven_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dq_out == $past(dq_out)));

    assert_oe_high_open_R4: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> !dq_oe);

    assert_early_write_open_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EWRITE) |-> !dq_oe);

    assert_late_write_open_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LWRITE) |-> !dq_oe);

    assert_indet_not_driven_R10: assert property (@(posedge clk) disable iff (rst)
        dq_indet |-> !dq_oe);

    assert_refresh_open_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REFRESH) |-> !dq_oe);

    assert_open_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));

endmodule

bind dqc_output_ctrl dqc_output_ctrl_chk #(.DQ_W(DQ_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cas_n    (cas_n),
    .oe_n     (oe_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .dq_indet (dq_indet),
    .st       (cyc_state)
);

// File: tb/dqc_output_ctrl_tb_top.sv
module dqc_output_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [3:0] rd_data = 4'h0;
    logic [3:0] dq_out;
    logic       dq_oe;
    logic       dq_indet;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dqc_output_ctrl #(.DQ_W(4)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .rd_data  (rd_data),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .dq_indet (dq_indet)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected = {oe, indet, data}
    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {dq_oe, dq_indet, dq_out};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual oe=%b indet=%b dq=%h expected oe=%b indet=%b dq=%h",
                     tag, act[5], act[4], act[3:0], exp[5], exp[4], exp[3:0]);
        end
    endtask

    task automatic idle_all();
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step(3);
    endtask

    task automatic start_read(input logic [3:0] d);
        rd_data = d; oe_n = 1'b0; ras_n = 1'b0;
        step(1);
        cas_n = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        chk("R1 reset state", 6'b00_0000);
    endtask

    task automatic t_read_basic();
        rd_data = 4'hA; oe_n = 1'b0; ras_n = 1'b0;
        step(1);
        cas_n = 1'b0;
        step(1);
        chk("R2 not driven one clock after cas", 6'b00_0000);
        step(1);
        chk("R2 read data driven", {2'b10, 4'hA});
        rd_data = 4'h3;
        step(2);
        chk("R3 rd_data change ignored", {2'b10, 4'hA});
        oe_n = 1'b1;
        step(1);
        chk("R4 oe high opens", 6'b00_0000);
        oe_n = 1'b0;
        step(1);
        chk("R4 oe low restores data", {2'b10, 4'hA});
        ras_n = 1'b1;
        step(2);
        chk("R5 ras high holds data", {2'b10, 4'hA});
        rd_data = 4'h5; ras_n = 1'b0;
        step(2);
        chk("R5 new ras fall holds data", {2'b10, 4'hA});
        cas_n = 1'b1;
        step(1);
        chk("R1 cas high opens with oe low", 6'b00_0000);
        step(1);
        chk("R6 precharge keeps open", 6'b00_0000);
        cas_n = 1'b0;
        step(2);
        chk("R6 fresh data after precharge", {2'b10, 4'h5});
        idle_all();
        chk("R12 idle zeros", 6'b00_0000);
    endtask

    task automatic t_early_write();
        rd_data = 4'hC; ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        step(2);
        cas_n = 1'b0;
        step(3);
        chk("R7 early write open", 6'b00_0000);
        oe_n = 1'b1;
        step(1);
        oe_n = 1'b0;
        step(2);
        chk("R7 early write open after oe toggle", 6'b00_0000);
        idle_all();
    endtask

    task automatic t_rmw();
        start_read(4'h9);
        chk("R8 read before modify", {2'b10, 4'h9});
        we_n = 1'b0;
        step(1);
        chk("R8 driven at we fall", {2'b10, 4'h9});
        step(2);
        chk("R8 rmw keeps data, no indet", {2'b10, 4'h9});
        idle_all();
    endtask

    task automatic t_late_write();
        start_read(4'h6);
        oe_n = 1'b1;
        step(1);
        we_n = 1'b0;
        step(2);
        chk("R9 late write open", 6'b00_0000);
        oe_n = 1'b0;
        step(2);
        chk("R9 stays open after oe low", 6'b00_0000);
        idle_all();
        chk("R9 released after cas rise", 6'b00_0000);
    endtask

    task automatic t_indet();
        rd_data = 4'hF; ras_n = 1'b0; oe_n = 1'b0;
        step(1);
        cas_n = 1'b0; we_n = 1'b0;
        step(2);
        chk("R10 simultaneous edges indeterminate", 6'b01_0000);
        oe_n = 1'b1;
        step(1);
        oe_n = 1'b0;
        step(2);
        chk("R10 indeterminate held", 6'b01_0000);
        cas_n = 1'b1;
        step(2);
        chk("R10 cleared by cas rise", 6'b00_0000);
        idle_all();
    endtask

    task automatic t_refresh();
        rd_data = 4'h7; oe_n = 1'b0; ras_n = 1'b1;
        step(1);
        cas_n = 1'b0;
        step(2);
        chk("R11 refresh open", 6'b00_0000);
        ras_n = 1'b0;
        step(3);
        chk("R11 refresh open after ras fall", 6'b00_0000);
        idle_all();
        start_read(4'h2);
        chk("R11 read after refresh", {2'b10, 4'h2});
        idle_all();
    endtask

    initial begin
        rst = 1'b1;
        step(4);
        rst = 1'b0;
        step(2);
        t_reset();
        t_read_basic();
        t_early_write();
        t_rmw();
        t_late_write();
        t_indet();
        t_refresh();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule